// File: doc/BRIEF.md
# Joystick SPI Packet Sequencer

This block runs the byte-level conversation with an SPI joystick peripheral. It does not shift bits itself. It hands bytes to a separate SPI master through an outgoing byte stream, and it takes back the bytes that master receives. The outgoing stream has valid, data and ready. The return stream has valid and data only.

Each packet has five bytes. The first is a fixed colour-setting command. The next three carry the red, green and blue LED levels. A zero padding byte follows, so that five reply bytes come back. The block waits a programmable number of microseconds after every byte, and one extra interval after each packet. The reply carries two split 10-bit axis values and a button byte. The block rebuilds these and updates all joystick outputs in one cycle once a complete reply has arrived.

The pause length comes from two parameters, the clock frequency and the pause in microseconds. After reset the block starts on its own and keeps sending packets for as long as it is clocked.

Top module: `jstk_pkt_seq`

## Requirements
- R1: The first byte of every packet is the command value 0x84.
- R2: Packet bytes two, three and four carry the red, green and blue levels, in that order. All three are sampled on the cycle the command byte is first presented. Level changes later in the packet do not alter them.
- R3: The fifth byte of every packet is the padding value 0x00.
- R4: After any of the first four bytes of a packet is accepted, tx_valid stays low for exactly N cycles before the next byte is presented, where N = (CLK_HZ / 1000000) * GAP_US.
- R5: After the fifth byte of a packet is accepted, tx_valid stays low for exactly 2N cycles before the next command byte.
- R6: While tx_valid is high and tx_ready is low, tx_valid stays high and tx_data stays unchanged.
- R7: The reply bytes of a packet are taken in this order: X low, X high, Y low, Y high, buttons. The 10-bit X output is {X high bits 1:0, X low}, and Y is formed the same way. Bits 7:2 of the high bytes are ignored.
- R8: Bit 0 of the button reply byte drives btn_stick and bit 1 drives btn_trig. Its other bits are ignored.
- R9: pos_x, pos_y, btn_stick and btn_trig change together, one cycle after the fifth reply byte of a packet is received, and at no other time. A packet with fewer than five reply bytes leaves them unchanged.
- R10: The reply byte index restarts at zero when a command byte is accepted. A packet that follows a truncated reply is decoded correctly.
- R11: Return-stream bytes after the fifth of a packet are ignored until the next command byte.
- R12: Reset is synchronous and active low. While it is held, tx_valid is 0 and all joystick outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_ready | input | 1 | Outgoing byte accepted by the SPI master |
| rx_valid | input | 1 | Received byte valid, accepted on any cycle |
| rx_data | input | 8 | Received byte |
| led_red | input | 8 | Red LED level |
| led_grn | input | 8 | Green LED level |
| led_blu | input | 8 | Blue LED level |
| pos_x | output | 10 | Joystick X position |
| pos_y | output | 10 | Joystick Y position |
| btn_stick | output | 1 | Stick-press button |
| btn_trig | output | 1 | Trigger button |

## Verification
A wrong transmit index shows up on the very next accepted byte, as a misplaced command, colour or padding value. A wrong pause counter shows up when the following byte is presented, as a low period of the wrong length.

Faults in the receive index take longer to appear. They surface only one cycle after a fifth reply byte, as swapped or shifted axis halves. They can also appear as outputs that move after an incomplete or over-long reply. For that reason the bench mixes truncated replies and surplus bytes into its random packets.

// File: rtl/jstk_pkg.sv
package jstk_pkg;

  localparam int          PKT_LEN     = 5;
  localparam int          AXIS_W      = 10;
  localparam logic [7:0]  CMD_SET_RGB = 8'h84;
  localparam logic [7:0]  PAD_BYTE    = 8'h00;

  typedef enum logic {
    TX_WAIT = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  // Pause length in clock cycles, never below one.
  function automatic int gap_cycles(input int clk_hz, input int gap_us);
    int c;
    c = (clk_hz / 1000000) * gap_us;
    return (c < 1) ? 1 : c;
  endfunction

  // Byte to transmit at a given packet position.
  function automatic logic [7:0] pkt_byte(input logic [2:0] pos,
                                          input logic [7:0] r,
                                          input logic [7:0] g,
                                          input logic [7:0] b);
    case (pos)
      3'd0:    return CMD_SET_RGB;
      3'd1:    return r;
      3'd2:    return g;
      3'd3:    return b;
      default: return PAD_BYTE;
    endcase
  endfunction

  // Rebuild a split axis value from its low byte and two high bits.
  function automatic logic [AXIS_W-1:0] join_axis(input logic [7:0] lo,
                                                  input logic [1:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/jstk_tx_pacer.sv
module jstk_tx_pacer
  import jstk_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int GAP_US = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] led_red,
  input  logic [7:0] led_grn,
  input  logic [7:0] led_blu,
  input  logic       tx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  output logic       tx_accept,
  output logic       pkt_start
);

  localparam int GAP_CYC = gap_cycles(CLK_HZ, GAP_US);
  localparam int CNT_W   = $clog2(2 * GAP_CYC + 1);
  localparam logic [CNT_W-1:0] LD_BYTE = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_PKT  = CNT_W'(2 * GAP_CYC - 1);
  localparam logic [2:0]       POS_LAST = 3'(PKT_LEN - 1);

  tx_state_e        state;
  logic [CNT_W-1:0] wait_cnt;
  logic [2:0]       pos;
  logic [7:0]       lat_r, lat_g, lat_b;
  logic             wait_done;

  assign wait_done = (state == TX_WAIT) && (wait_cnt == '0);
  assign tx_valid  = (state == TX_SEND);
  assign tx_accept = tx_valid && tx_ready;
  assign pkt_start = tx_accept && (pos == 3'd0);
  assign tx_data   = pkt_byte(pos, lat_r, lat_g, lat_b);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= TX_WAIT;
      wait_cnt <= LD_BYTE;
      pos      <= 3'd0;
      lat_r    <= 8'h00;
      lat_g    <= 8'h00;
      lat_b    <= 8'h00;
    end else begin
      case (state)
        TX_WAIT: begin
          if (wait_done) begin
            state <= TX_SEND;
            if (pos == 3'd0) begin
              lat_r <= led_red;
              lat_g <= led_grn;
              lat_b <= led_blu;
            end
          end else begin
            wait_cnt <= wait_cnt - 1'b1;
          end
        end
        default: begin
          if (tx_ready) begin
            state <= TX_WAIT;
            if (pos == POS_LAST) begin
              pos      <= 3'd0;
              wait_cnt <= LD_PKT;
            end else begin
              pos      <= pos + 3'd1;
              wait_cnt <= LD_BYTE;
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/jstk_rx_collect.sv
module jstk_rx_collect
  import jstk_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_start,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic [AXIS_W-1:0] pos_x,
  output logic [AXIS_W-1:0] pos_y,
  output logic              btn_stick,
  output logic              btn_trig,
  output logic [2:0]        rx_idx,
  output logic              upd_fire
);

  localparam logic [2:0] IDX_DONE = 3'(PKT_LEN);
  localparam logic [2:0] IDX_BTN  = 3'(PKT_LEN - 1);

  logic [7:0] x_lo, y_lo;
  logic [1:0] x_hi, y_hi;
  logic       take;

  assign take     = rx_valid && !pkt_start && (rx_idx < IDX_DONE);
  assign upd_fire = take && (rx_idx == IDX_BTN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_idx    <= IDX_DONE;
      x_lo      <= 8'h00;
      x_hi      <= 2'b00;
      y_lo      <= 8'h00;
      y_hi      <= 2'b00;
      pos_x     <= '0;
      pos_y     <= '0;
      btn_stick <= 1'b0;
      btn_trig  <= 1'b0;
    end else if (pkt_start) begin
      rx_idx <= 3'd0;
    end else if (take) begin
      rx_idx <= rx_idx + 3'd1;
      case (rx_idx)
        3'd0:    x_lo <= rx_data;
        3'd1:    x_hi <= rx_data[1:0];
        3'd2:    y_lo <= rx_data;
        3'd3:    y_hi <= rx_data[1:0];
        default: ;
      endcase
      if (upd_fire) begin
        pos_x     <= join_axis(x_lo, x_hi);
        pos_y     <= join_axis(y_lo, y_hi);
        btn_stick <= rx_data[0];
        btn_trig  <= rx_data[1];
      end
    end
  end

endmodule

// File: rtl/jstk_pkt_seq.sv
module jstk_pkt_seq
  import jstk_pkg::*;
#(
  parameter int CLK_HZ = 100_000_000,
  parameter int GAP_US = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic [7:0] led_red,
  input  logic [7:0] led_grn,
  input  logic [7:0] led_blu,
  output logic [9:0] pos_x,
  output logic [9:0] pos_y,
  output logic       btn_stick,
  output logic       btn_trig
);

  // Named internal events, observed by the bound checker.
  logic       tx_accept;
  logic       pkt_start;
  logic [2:0] rx_idx;
  logic       upd_fire;

  jstk_tx_pacer #(
    .CLK_HZ(CLK_HZ),
    .GAP_US(GAP_US)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .led_red   (led_red),
    .led_grn   (led_grn),
    .led_blu   (led_blu),
    .tx_ready  (tx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_accept (tx_accept),
    .pkt_start (pkt_start)
  );

  jstk_rx_collect u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .pkt_start (pkt_start),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .pos_x     (pos_x),
    .pos_y     (pos_y),
    .btn_stick (btn_stick),
    .btn_trig  (btn_trig),
    .rx_idx    (rx_idx),
    .upd_fire  (upd_fire)
  );

endmodule

// File: rtl/jstk_pkt_seq_chk.sv
module jstk_pkt_seq_chk
  import jstk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_accept,
  input logic       pkt_start,
  input logic [2:0] rx_idx,
  input logic       upd_fire,
  input logic [9:0] pos_x,
  input logic [9:0] pos_y,
  input logic       btn_stick,
  input logic       btn_trig
);

  p_cmd_lead_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |-> (tx_data == CMD_SET_RGB));

  p_pause_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_accept |=> !tx_valid);

  p_hold_until_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_out_only_on_fifth_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_fire |=> ($stable(pos_x) && $stable(pos_y) && $stable(btn_stick) && $stable(btn_trig)));

  p_index_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_start |=> (rx_idx == 3'd0));

  p_surplus_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((rx_idx == 3'(PKT_LEN)) && !pkt_start) |=> (rx_idx == 3'(PKT_LEN)));

endmodule

bind jstk_pkt_seq jstk_pkt_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_data   (tx_data),
  .tx_accept (tx_accept),
  .pkt_start (pkt_start),
  .rx_idx    (rx_idx),
  .upd_fire  (upd_fire),
  .pos_x     (pos_x),
  .pos_y     (pos_y),
  .btn_stick (btn_stick),
  .btn_trig  (btn_trig)
);

// File: tb/jstk_pkt_seq_tb.sv
module jstk_pkt_seq_tb;

  localparam int CLK_HZ = 2_000_000;
  localparam int GAP_US = 3;
  localparam int GAP    = (CLK_HZ / 1000000) * GAP_US;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       tx_ready = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic [7:0] led_red = 8'h00, led_grn = 8'h00, led_blu = 8'h00;
  logic [9:0] pos_x, pos_y;
  logic       btn_stick, btn_trig;

  always #5 clk = ~clk;

  jstk_pkt_seq #(.CLK_HZ(CLK_HZ), .GAP_US(GAP_US)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .rx_valid(rx_valid), .rx_data(rx_data),
    .led_red(led_red), .led_grn(led_grn), .led_blu(led_blu),
    .pos_x(pos_x), .pos_y(pos_y), .btn_stick(btn_stick), .btn_trig(btn_trig)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int p, input logic [7:0] r,
                                          input logic [7:0] g, input logic [7:0] b);
    case (p)
      0:       return 8'h84;
      1:       return r;
      2:       return g;
      3:       return b;
      default: return 8'h00;
    endcase
  endfunction

  initial begin
    int bpos, last_pos, low_cnt, pkt_done, cyc, rep_cnt, extra_cnt, exp_gap;
    bit seen_acc, prev_valid, prev_ready, trunc, prev_trunc, extra;
    bit upd_pending, extra_chk, rep_last;
    logic [7:0] prev_data, cap_r, cap_g, cap_b, rep_byte;
    logic [7:0] rb [5];
    logic [9:0] px, py, exp_x, exp_y;
    logic [1:0] pb, exp_b;
    string tag, btag;

    bpos = 0; last_pos = 0; low_cnt = 0; pkt_done = 0; cyc = 0;
    rep_cnt = 0; extra_cnt = 0;
    seen_acc = 0; prev_valid = 0; prev_ready = 0; trunc = 0; prev_trunc = 0;
    extra = 0; upd_pending = 0; extra_chk = 0; rep_last = 0;
    prev_data = 0; cap_r = 0; cap_g = 0; cap_b = 0; rep_byte = 0;
    px = 0; py = 0; pb = 0; exp_x = 0; exp_y = 0; exp_b = 0;
    for (int i = 0; i < 5; i++) rb[i] = 8'h00;
    void'($urandom(32'h1d5a));

    // Reset phase, R12
    led_red = 8'hA5; led_grn = 8'h5A; led_blu = 8'hFF;
    repeat (3) @(negedge clk);
    chk(tx_valid == 1'b0, "R12", int'(tx_valid), 0);
    chk(pos_x == 10'd0 && pos_y == 10'd0, "R12", int'({pos_x, pos_y}), 0);
    chk(btn_stick == 1'b0 && btn_trig == 1'b0, "R12", int'({btn_trig, btn_stick}), 0);
    rst_n = 1'b1;

    while (pkt_done < 40 && cyc < 20000) begin
      @(negedge clk);
      cyc++;

      // Observe
      if (!tx_valid) low_cnt++;
      if (tx_valid && !prev_valid) begin
        if (seen_acc) begin
          exp_gap = (last_pos == 4) ? 2 * GAP : GAP;
          chk(low_cnt == exp_gap, (last_pos == 4) ? "R5" : "R4", low_cnt, exp_gap);
        end
        if (bpos == 0) begin
          cap_r = led_red; cap_g = led_grn; cap_b = led_blu;
        end
      end
      if (prev_valid && !prev_ready)
        chk(tx_valid && tx_data == prev_data, "R6", int'({tx_valid, tx_data}), int'({1'b1, prev_data}));

      tag = "R9"; btag = "R9";
      if (upd_pending) begin
        exp_x = px; exp_y = py; exp_b = pb;
        tag = prev_trunc ? "R10" : "R7"; btag = "R8";
        upd_pending = 0;
      end
      if (extra_chk) begin
        tag = "R11"; btag = "R11"; extra_chk = 0;
      end
      chk(pos_x == exp_x, tag, int'(pos_x), int'(exp_x));
      chk(pos_y == exp_y, tag, int'(pos_y), int'(exp_y));
      chk({btn_trig, btn_stick} == exp_b, btag, int'({btn_trig, btn_stick}), int'(exp_b));

      // Drive the outgoing handshake
      prev_valid = tx_valid;
      prev_data  = tx_data;
      tx_ready   = ($urandom_range(3) != 0);
      prev_ready = tx_ready;
      if (tx_valid && tx_ready) begin
        if (bpos == 0) begin
          prev_trunc = trunc;
          trunc = (pkt_done == 2) || (pkt_done > 5 && $urandom_range(5) == 0);
          extra = (pkt_done == 3) || ($urandom_range(4) == 0);
          px = 10'($urandom); py = 10'($urandom); pb = 2'($urandom);
          if (pkt_done == 0) begin px = 10'h3FF; py = 10'h000; pb = 2'b01; end
          if (pkt_done == 1) begin px = 10'h000; py = 10'h3FF; pb = 2'b10; end
          rb[0] = px[7:0];
          rb[1] = {6'($urandom), px[9:8]};
          rb[2] = py[7:0];
          rb[3] = {6'($urandom), py[9:8]};
          rb[4] = {6'($urandom), pb};
        end
        chk(tx_data == exp_byte(bpos, cap_r, cap_g, cap_b),
            (bpos == 0) ? "R1" : (bpos == 4) ? "R3" : "R2",
            int'(tx_data), int'(exp_byte(bpos, cap_r, cap_g, cap_b)));
        if (!(trunc && bpos > 2)) begin
          rep_cnt = 2; rep_byte = rb[bpos]; rep_last = (bpos == 4);
        end
        last_pos = bpos; seen_acc = 1; low_cnt = 0;
        if (bpos == 4) begin
          pkt_done++; bpos = 0;
        end else begin
          bpos++;
        end
      end

      // Drive the return stream
      rx_valid = 1'b0;
      if (rep_cnt > 0) begin
        rep_cnt--;
        if (rep_cnt == 0) begin
          rx_valid = 1'b1; rx_data = rep_byte;
          if (rep_last) begin
            upd_pending = 1;
            if (extra) extra_cnt = 3;
          end
        end
      end else if (extra_cnt > 0) begin
        extra_cnt--;
        if (extra_cnt == 0) begin
          rx_valid = 1'b1; rx_data = 8'($urandom); extra_chk = 1;
        end
      end

      // LED levels wander, including mid-packet (R2)
      if ($urandom_range(7) == 0) begin
        led_red = 8'($urandom); led_grn = 8'($urandom); led_blu = 8'($urandom);
      end
    end

    if (cyc >= 20000) chk(1'b0, "watchdog", cyc, 20000);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule